// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the byte-wide register port through which software sets up a four-channel DMA controller. A host writes and reads 8-bit values at a 4-bit offset. Each channel owns a 16-bit base address and a 16-bit base count. Each of these sits behind one 8-bit offset and is moved as two byte accesses in a row, low byte first. One byte-pointer flip-flop, shared by every channel, steers those accesses. Software resets the pointer on purpose before each 16-bit access.

Besides the channel registers, the port holds a per-channel mode, a per-channel mask bit and a command byte. It also accepts commands that clear the byte pointer, clear every mask, load every mask at once, and perform a master clear. The programmed values leave the block as flat vectors for a transfer engine. The engine returns its working address and count, and these are what a read of a channel offset shows. It also returns terminal-count pulses and live request lines, which form the status byte.

Top module: `dmap_prog_port`

## Requirements
- R1: After reset every mask bit is 1, the byte pointer selects the low byte, and the base address, base count, mode and command outputs are all zero.
- R2: A write at offset 2n goes to the base address of channel n, and a write at offset 2n+1 goes to its base count (n = 0..3). The byte pointer picks which byte is written: low byte when the pointer is low, high byte when it is high. The count is kept exactly as written, as the number of transfers minus one. Other channels are left unchanged.
- R3: Every read or write at offsets 0..7 flips the byte pointer after the access. Accesses at offsets 8..15 leave it as it is, except for the two commands in R4 and R10.
- R4: A write at offset 0xC forces the byte pointer low, whatever the data byte.
- R5: A read at offset 2n returns one byte of channel n's working address input, and a read at offset 2n+1 returns one byte of its working count input. The low or high byte is picked by the byte pointer. The read data is 0 whenever the read strobe is low.
- R6: A write at offset 0xA changes one mask bit. Data bits 1:0 pick the channel, and data bit 2 gives the new mask value. The other mask bits are unchanged.
- R7: A write at offset 0xB stores data bits 7:2 as the 6-bit mode of the channel picked by data bits 1:0. Inside the stored field, bit 2 is auto-initialize (data bit 4), bits 1:0 are the direction (data bits 3:2), and bits 5:4 are the transfer mode (data bits 7:6).
- R8: A write at offset 0xE clears all mask bits. A write at offset 0xF loads mask bits 3:0 from data bits 3:0.
- R9: A write at offset 0x8 stores the command byte. A read at offset 0x8 returns the request inputs in bits 7:4 and the sticky terminal-count flags in bits 3:0. That read clears the flags, but a terminal-count pulse in the same cycle still sets its flag.
- R10: A write at offset 0xD is a master clear. It sets all mask bits, clears the command byte and the terminal-count flags, and forces the byte pointer low. Base registers and modes keep their values. A read at offset 0xD returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset and pointer |
| cur_addr_i | input | 64 | Working address from the engine, 16 bits per channel |
| cur_cnt_i | input | 64 | Working count from the engine, 16 bits per channel |
| tc_i | input | 4 | Terminal-count pulses, one per channel |
| req_i | input | 4 | Live request lines, one per channel |
| base_addr_o | output | 64 | Programmed base addresses, channel 0 in the low 16 bits |
| base_cnt_o | output | 64 | Programmed base counts (transfers minus one) |
| mode_o | output | 24 | Programmed modes, 6 bits per channel |
| mask_o | output | 4 | Channel mask bits, 1 = disabled |
| cmd_o | output | 8 | Command byte |

## Verification
The bench works the byte pointer across channels. For example, a count read followed by an address read of another channel must return that channel's high byte. A design with a pointer per channel would return the low byte instead. The bench clears the pointer in the middle of a sequence with a nonzero data byte, which exposes a clear that depends on the data. It also reads the status and temporary offsets between channel reads, so a pointer that flips on every access would shift every later byte. It sends a terminal-count pulse in the same cycle as the status read, so a design where the clear wins would lose that flag. It checks that master clear restores the masks and the pointer but keeps the programmed base values and modes.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    OFS_CMD      = 4'h8,
    OFS_MASK_ONE = 4'hA,
    OFS_MODE     = 4'hB,
    OFS_CLR_PTR  = 4'hC,
    OFS_MCLR     = 4'hD,
    OFS_CLR_MASK = 4'hE,
    OFS_MASK_ALL = 4'hF
  } ofs_e;

  typedef struct packed {
    logic ch_acc;
    logic ch_wr;
    logic cmd_wr;
    logic stat_rd;
    logic mask_one_wr;
    logic mode_wr;
    logic clr_ptr_wr;
    logic mclr_wr;
    logic clr_mask_wr;
    logic mask_all_wr;
  } dec_t;
endpackage

// File: rtl/dmap_byte_ptr.sv
module dmap_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic toggle_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clear_i)  hi_o <= 1'b0;
    else if (toggle_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dmap_chan_regs.sv
module dmap_chan_regs #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [$clog2(NCH):0]           sel_i,
  input  logic                           hi_i,
  input  logic                           mode_wr_i,
  input  logic [DW-1:0]                  wdata_i,
  output logic [NCH*2*DW-1:0]            base_addr_o,
  output logic [NCH*2*DW-1:0]            base_cnt_o,
  output logic [NCH*(DW-$clog2(NCH))-1:0] mode_o
);
  localparam int unsigned CH_W = $clog2(NCH);
  localparam int unsigned VW   = 2 * DW;
  localparam int unsigned MW   = DW - CH_W;

  logic [CH_W-1:0] ch_sel;
  logic            is_cnt;
  assign ch_sel = sel_i[CH_W:1];
  assign is_cnt = sel_i[0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [VW-1:0] addr_q, cnt_q;
    logic [MW-1:0] mode_q;
    logic          hit;
    assign hit = wr_i && (ch_sel == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        cnt_q  <= '0;
      end else if (hit) begin
        if (is_cnt) begin
          if (hi_i) cnt_q[VW-1:DW]  <= wdata_i;
          else      cnt_q[DW-1:0]   <= wdata_i;
        end else begin
          if (hi_i) addr_q[VW-1:DW] <= wdata_i;
          else      addr_q[DW-1:0]  <= wdata_i;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q <= '0;
      else if (mode_wr_i && (wdata_i[CH_W-1:0] == CH_W'(c)))
        mode_q <= wdata_i[DW-1:CH_W];
    end

    assign base_addr_o[c*VW +: VW] = addr_q;
    assign base_cnt_o[c*VW +: VW]  = cnt_q;
    assign mode_o[c*MW +: MW]      = mode_q;
  end
endmodule

// File: rtl/dmap_ctrl_regs.sv
module dmap_ctrl_regs #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dmap_pkg::dec_t   dec_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NCH-1:0]   tc_i,
  input  logic [NCH-1:0]   req_i,
  output logic [NCH-1:0]   mask_o,
  output logic [DW-1:0]    cmd_o,
  output logic [2*NCH-1:0] status_o
);
  localparam int unsigned CH_W    = $clog2(NCH);
  localparam int unsigned MSK_BIT = 2;

  logic [NCH-1:0] tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_o <= '1;
    else if (dec_i.mclr_wr)     mask_o <= '1;
    else if (dec_i.clr_mask_wr) mask_o <= '0;
    else if (dec_i.mask_all_wr) mask_o <= wdata_i[NCH-1:0];
    else if (dec_i.mask_one_wr) mask_o[wdata_i[CH_W-1:0]] <= wdata_i[MSK_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cmd_o <= '0;
    else if (dec_i.mclr_wr) cmd_o <= '0;
    else if (dec_i.cmd_wr)  cmd_o <= wdata_i;
  end

  // a pulse arriving with the status read survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tc_q <= '0;
    else if (dec_i.mclr_wr) tc_q <= tc_i;
    else                    tc_q <= (dec_i.stat_rd ? '0 : tc_q) | tc_i;
  end

  assign status_o = {req_i, tc_q};
endmodule

// File: rtl/dmap_prog_port.sv
module dmap_prog_port #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic                             rd_i,
  input  logic [dmap_pkg::AW-1:0]          addr_i,
  input  logic [DW-1:0]                    wdata_i,
  output logic [DW-1:0]                    rdata_o,
  input  logic [NCH*2*DW-1:0]              cur_addr_i,
  input  logic [NCH*2*DW-1:0]              cur_cnt_i,
  input  logic [NCH-1:0]                   tc_i,
  input  logic [NCH-1:0]                   req_i,
  output logic [NCH*2*DW-1:0]              base_addr_o,
  output logic [NCH*2*DW-1:0]              base_cnt_o,
  output logic [NCH*(DW-$clog2(NCH))-1:0]  mode_o,
  output logic [NCH-1:0]                   mask_o,
  output logic [DW-1:0]                    cmd_o
);
  import dmap_pkg::*;

  localparam int unsigned CH_W = $clog2(NCH);
  localparam int unsigned VW   = 2 * DW;
  localparam logic [AW-1:0] CH_LIM = AW'(2 * NCH);

  dec_t             dec;
  logic             ptr_hi;
  logic [2*NCH-1:0] status;
  logic             in_ch;

  assign in_ch = addr_i < CH_LIM;

  always_comb begin
    dec             = '0;
    dec.ch_acc      = (wr_i || rd_i) && in_ch;
    dec.ch_wr       = wr_i && in_ch;
    dec.stat_rd     = rd_i && (addr_i == OFS_CMD);
    if (wr_i) begin
      unique case (addr_i)
        OFS_CMD:      dec.cmd_wr      = 1'b1;
        OFS_MASK_ONE: dec.mask_one_wr = 1'b1;
        OFS_MODE:     dec.mode_wr     = 1'b1;
        OFS_CLR_PTR:  dec.clr_ptr_wr  = 1'b1;
        OFS_MCLR:     dec.mclr_wr     = 1'b1;
        OFS_CLR_MASK: dec.clr_mask_wr = 1'b1;
        OFS_MASK_ALL: dec.mask_all_wr = 1'b1;
        default: ;
      endcase
    end
  end

  dmap_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (dec.clr_ptr_wr || dec.mclr_wr),
    .toggle_i (dec.ch_acc),
    .hi_o     (ptr_hi)
  );

  dmap_chan_regs #(.NCH(NCH), .DW(DW)) u_chan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (dec.ch_wr),
    .sel_i       (addr_i[CH_W:0]),
    .hi_i        (ptr_hi),
    .mode_wr_i   (dec.mode_wr),
    .wdata_i     (wdata_i),
    .base_addr_o (base_addr_o),
    .base_cnt_o  (base_cnt_o),
    .mode_o      (mode_o)
  );

  dmap_ctrl_regs #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec),
    .wdata_i  (wdata_i),
    .tc_i     (tc_i),
    .req_i    (req_i),
    .mask_o   (mask_o),
    .cmd_o    (cmd_o),
    .status_o (status)
  );

  logic [CH_W-1:0] rd_ch;
  logic [VW-1:0]   rd_word;
  assign rd_ch   = addr_i[CH_W:1];
  assign rd_word = addr_i[0] ? cur_cnt_i[rd_ch*VW +: VW] : cur_addr_i[rd_ch*VW +: VW];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (in_ch)                   rdata_o = ptr_hi ? rd_word[VW-1:DW] : rd_word[DW-1:0];
      else if (addr_i == OFS_CMD)  rdata_o = DW'(status);
    end
  end
endmodule

// File: rtl/dmap_prog_port_chk.sv
module dmap_prog_port_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_i,
  input logic           rd_i,
  input logic [3:0]     addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [NCH-1:0] mask_o,
  input logic [DW-1:0]  cmd_o,
  input logic           ptr_hi_i
);
  localparam int unsigned CH_W = $clog2(NCH);
  localparam logic [3:0] LIM = 4'(2 * NCH);

  // R8
  clr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 4'hE |=> mask_o == '0);
  // R8
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 4'hF |=> mask_o == $past(wdata_i[NCH-1:0]));
  // R10
  mclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 4'hD |=> (&mask_o) && cmd_o == '0 && !ptr_hi_i);
  // R4
  clr_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 4'hC |=> !ptr_hi_i);
  // R3
  ptr_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) && addr_i < LIM |=> ptr_hi_i != $past(ptr_hi_i));
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((wr_i || rd_i) && addr_i < LIM) && !(wr_i && (addr_i == 4'hC || addr_i == 4'hD))
    |=> $stable(ptr_hi_i));
  // R6
  mask_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 4'hA |=> mask_o[$past(wdata_i[CH_W-1:0])] == $past(wdata_i[2]));
endmodule

bind dmap_prog_port dmap_prog_port_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .mask_o   (mask_o),
  .cmd_o    (cmd_o),
  .ptr_hi_i (ptr_hi)
);

// File: tb/dmap_prog_port_test.sv
module dmap_prog_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {is_read, offset, data, expected read byte}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'hC, 8'h00, 8'h00},
    {1'b1, 4'h0, 8'h00, 8'h34},
    {1'b1, 4'h0, 8'h00, 8'h12},
    {1'b1, 4'h1, 8'h00, 8'hED},
    {1'b1, 4'h2, 8'h00, 8'h56},
    {1'b1, 4'h7, 8'h00, 8'hFF},
    {1'b0, 4'hC, 8'h5A, 8'h00},
    {1'b1, 4'h6, 8'h00, 8'hF0},
    {1'b1, 4'h5, 8'h00, 8'h13},
    {1'b1, 4'h8, 8'h00, 8'h00},
    {1'b1, 4'h4, 8'h00, 8'hBC},
    {1'b1, 4'hD, 8'h00, 8'h00},
    {1'b1, 4'h4, 8'h00, 8'h9A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [63:0] cur_addr = {16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
  logic [63:0] cur_cnt  = {16'hFFFF, 16'h1357, 16'h2468, 16'h0FED};
  logic [3:0]  tc = '0, req = '0;
  logic [63:0] base_addr, base_cnt;
  logic [23:0] mode;
  logic [3:0]  mask;
  logic [7:0]  cmd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmap_prog_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt),
    .tc_i(tc), .req_i(req), .base_addr_o(base_addr), .base_cnt_o(base_cnt),
    .mode_o(mode), .mask_o(mask), .cmd_o(cmd)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 chk(64'(rdata), 64'(exp), req);
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(64'(mask), 64'hF, "R1 mask");
    chk(64'(cmd), 64'h0, "R1 cmd");
    chk(base_addr, 64'h0, "R1 base_addr");
    chk(base_cnt, 64'h0, "R1 base_cnt");
    chk(64'(mode), 64'h0, "R1 mode");
    chk(64'(rdata), 64'h0, "R5 idle rdata");
    rd_b(4'h0, 8'h34, "R1 pointer low");
    // R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rd_b(VEC[i][19:16], VEC[i][7:0], "R3/R5 vector");
      else            wr_b(VEC[i][19:16], VEC[i][15:8]);
    end
    // R2 base programming
    wr_b(4'hC, 8'h00);
    wr_b(4'h4, 8'hCD); wr_b(4'h4, 8'hAB);
    wr_b(4'h7, 8'hFF); wr_b(4'h7, 8'hFF);
    wr_b(4'h1, 8'h00); wr_b(4'h1, 8'h00);
    chk(base_addr, 64'h0000_ABCD_0000_0000, "R2 addr ch2");
    chk(base_cnt,  64'hFFFF_0000_0000_0000, "R2 cnt ch3/ch0");
    wr_b(4'h3, 8'h22); wr_b(4'hC, 8'h77); wr_b(4'h3, 8'h44);
    chk(base_cnt, 64'hFFFF_0000_0044_0000, "R2 R4 cnt ch1 low rewrite");
    // R8 masks
    wr_b(4'hE, 8'hFF);
    chk(64'(mask), 64'h0, "R8 clear masks");
    // R6 single mask
    wr_b(4'hA, 8'h06); chk(64'(mask), 64'h4, "R6 set ch2");
    wr_b(4'hA, 8'h05); chk(64'(mask), 64'h6, "R6 set ch1");
    wr_b(4'hA, 8'hFA); chk(64'(mask), 64'h2, "R6 clear ch2");
    wr_b(4'hF, 8'hA9); chk(64'(mask), 64'h9, "R8 mask all");
    // R7 mode
    wr_b(4'hB, 8'h5A); chk(64'(mode), 64'(24'h016000), "R7 mode ch2");
    wr_b(4'hB, 8'hD7); chk(64'(mode), 64'(24'hD56000), "R7 mode ch3");
    // R9 command and status
    wr_b(4'h8, 8'hA5); chk(64'(cmd), 64'hA5, "R9 cmd");
    req = 4'b0100;
    @(negedge clk); tc = 4'b1010;
    @(negedge clk); tc = 4'b0000;
    rd_b(4'h8, 8'h4A, "R9 status flags");
    rd_b(4'h8, 8'h40, "R9 flags cleared");
    @(negedge clk); rd = 1'b1; addr = 4'h8; tc = 4'b0001;
    #1 chk(64'(rdata), 64'h40, "R9 read with pulse");
    @(negedge clk); rd = 1'b0; tc = 4'b0000;
    rd_b(4'h8, 8'h41, "R9 pulse kept");
    // R10 master clear
    @(negedge clk); tc = 4'b0100;
    @(negedge clk); tc = 4'b0000;
    wr_b(4'hC, 8'h00); wr_b(4'h0, 8'h11);
    wr_b(4'hD, 8'h00);
    chk(64'(mask), 64'hF, "R10 masks set");
    chk(64'(cmd), 64'h0, "R10 cmd cleared");
    chk(base_addr, 64'h0000_ABCD_0000_0011, "R10 base kept");
    chk(64'(mode), 64'(24'hD56000), "R10 mode kept");
    rd_b(4'h8, 8'h40, "R10 flags cleared");
    rd_b(4'h2, 8'h78, "R10 pointer low");
    rd_b(4'hD, 8'h00, "R10 temp read");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule